// File: doc/BRIEF.md
# Temperature-Scaled Next-Token Sampler

This block chooses one token out of a 27-symbol alphabet: index 0 is the end-of-word marker, and indices 1 through 26 are the letters in alphabetical order. Each symbol has a signed 16-bit logit with 11 fraction bits, and the logits sit in an external scratchpad. A `start` pulse launches a selection. The block reads the logits back through a read port whose data appears one cycle after the address. At the end it pulses `done` and presents the chosen index on `next_token`.

The block has two modes.

- **Argmax mode** returns the index of the largest logit.
- **Sampling mode** draws from a softmax distribution:
  - The gap of each logit below the maximum is scaled by the inverse temperature.
  - The result passes through a piecewise-linear exponential built on 17 table points.
  - The weights are added up.
  - A uniform draw from a 32-bit linear congruential generator is scaled by that total.
  - The first index whose running weight exceeds the scaled draw wins.

The generator state is exposed on `rng_state` so that it carries over from token to token. Software can reseed it while the block is idle. Every step uses exact integer arithmetic, so a given seed, temperature and set of logits always produce the same token.

Top module: `token_sampler`

## Requirements
- R1: After reset, `done` is 0, `next_token` is 0 and `rng_state` equals the parameter `RNG_RST` (default 1).
- R2: While no selection is running, a cycle with `seed_load` high and `start` low copies `seed_in` into `rng_state` on the next edge.
- R3: With `greedy` = 1, the result is the index of the largest logit under signed comparison; on equal logits the lowest index wins.
- R4: A selection in argmax mode leaves `rng_state` unchanged.
- R5: A selection in sampling mode advances the generator exactly once, as s' = s·1664525 + 1013904223 mod 2^32. The draw is bits 31:16 of s'.
- R6: In sampling mode each logit's gap below the maximum, g = max − logit ≥ 0, becomes m = (g·10) / (5 + `temp_code`), truncated. `temp_code` 0..7 stands for temperature 0.5..1.2 in steps of 0.1, and code 2 is the usual 0.7.
- R7: The weight of m uses table point k = round(32768·e^(−k/2)) for k = 0..16. With k = m >> 10 and f = m[9:0], the weight is t[k] − (((t[k] − t[k+1])·f) >> 10), where t[17] is taken as t[16]. Any m above 16384 (a gap beyond 8.0 after scaling) weighs 0.
- R8: With S the sum of all weights and d the draw, the threshold is (d·S) >> 16. The result is the lowest index whose cumulative weight is strictly greater than the threshold.
- R9: `done` is high for exactly one cycle per selection. `next_token` is updated on that cycle and held until the next selection finishes.
- R10: A `start` pulse raised while a selection is running is ignored; it produces no extra `done`.
- R11: The block reads only addresses 0 to 26 of the scratchpad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a selection (ignored while busy) |
| greedy | input | 1 | 1 = argmax, 0 = temperature sampling; captured at start |
| temp_code | input | 3 | Temperature code, T = 0.5 + 0.1·code; captured at start |
| seed_load | input | 1 | Load `seed_in` into the generator while idle |
| seed_in | input | 32 | Generator seed |
| rd_en | output | 1 | Scratchpad read strobe |
| rd_addr | output | 5 | Scratchpad logit address |
| rd_data | input | 16 | Logit returned one cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| next_token | output | 5 | Selected index |
| rng_state | output | 32 | Current generator state |

## Verification
The bench aims at the following corner cases, each paired with the wrong result a broken design would give:

| Corner case | A broken design would… |
|---|---|
| Tied maxima | return the later index of the tie |
| A logit of −32768 placed next to maxima of +32767, giving a 17-bit gap | wrap to a small negative gap and hand a nonzero weight to index 0 |
| A single peak 20.0 above every other logit | give the losers a weight above the cutoff and sometimes pick them |
| The highest and lowest temperature codes | divide by the wrong constant or round instead of truncate, and so shift the chosen token |
| An argmax run placed between sampling runs | advance the generator |
| A second `start` pulse mid-run | produce a spurious second `done` |

// File: rtl/smp_pkg.sv
package smp_pkg;
  typedef enum logic [1:0] {S_IDLE, S_MAX, S_SUM, S_PICK} smp_state_e;

  localparam int EXP_W   = 16;   // weight width, 1.0 = 32768
  localparam int STEP_SH = 10;   // table step 0.5 in Q5.11 = 1024
  localparam int TBL_LAST = 16;  // last table point index

  // round(32768 * e^(-k/2)), k = 0..16
  function automatic logic [EXP_W-1:0] exp_point(input logic [4:0] k);
    case (k)
      5'd0:  exp_point = 16'd32768;
      5'd1:  exp_point = 16'd19875;
      5'd2:  exp_point = 16'd12055;
      5'd3:  exp_point = 16'd7312;
      5'd4:  exp_point = 16'd4435;
      5'd5:  exp_point = 16'd2690;
      5'd6:  exp_point = 16'd1631;
      5'd7:  exp_point = 16'd990;
      5'd8:  exp_point = 16'd600;
      5'd9:  exp_point = 16'd364;
      5'd10: exp_point = 16'd221;
      5'd11: exp_point = 16'd134;
      5'd12: exp_point = 16'd81;
      5'd13: exp_point = 16'd49;
      5'd14: exp_point = 16'd30;
      5'd15: exp_point = 16'd18;
      default: exp_point = 16'd11;
    endcase
  endfunction
endpackage

// File: rtl/smp_scale.sv
module smp_scale #(
  parameter int GAP_W = 17,
  parameter int MAG_W = GAP_W + 4
) (
  input  logic [GAP_W-1:0] gap,
  input  logic [2:0]       tcode,
  output logic [MAG_W-1:0] mag
);
  logic [MAG_W-1:0] wide;
  logic [MAG_W-1:0] div;

  always_comb begin
    wide = MAG_W'(gap) * MAG_W'(10);
    div  = MAG_W'(5) + MAG_W'(tcode);
    mag  = wide / div;
  end
endmodule

// File: rtl/smp_exp.sv
module smp_exp
  import smp_pkg::*;
#(
  parameter int MAG_W = 21
) (
  input  logic [MAG_W-1:0] mag,
  output logic [EXP_W-1:0] weight
);
  localparam logic [MAG_W-1:0] LIMIT = MAG_W'(TBL_LAST) << STEP_SH;

  logic [4:0]            k;
  logic [STEP_SH-1:0]    frac;
  logic [EXP_W-1:0]      lo, hi, span;
  logic [EXP_W+STEP_SH-1:0] prod;

  always_comb begin
    k    = mag[STEP_SH+4:STEP_SH];
    frac = mag[STEP_SH-1:0];
    lo   = exp_point(k);
    hi   = (k >= 5'(TBL_LAST)) ? lo : exp_point(k + 5'd1);
    span = lo - hi;
    prod = (EXP_W+STEP_SH)'(span) * (EXP_W+STEP_SH)'(frac);
    if (mag > LIMIT) weight = '0;
    else             weight = lo - prod[EXP_W+STEP_SH-1:STEP_SH];
  end
endmodule

// File: rtl/smp_lcg.sv
module smp_lcg #(
  parameter int          SW  = 32,
  parameter logic [31:0] MUL = 32'd1664525,
  parameter logic [31:0] INC = 32'd1013904223
) (
  input  logic [SW-1:0] cur,
  output logic [SW-1:0] nxt
);
  always_comb nxt = cur * SW'(MUL) + SW'(INC);
endmodule

// File: rtl/token_sampler.sv
module token_sampler
  import smp_pkg::*;
#(
  parameter int          VOCAB   = 27,
  parameter int          DW      = 16,
  parameter int          RW      = 32,
  parameter logic [31:0] RNG_RST = 32'd1,
  localparam int         AW      = $clog2(VOCAB),
  localparam int         GAP_W   = DW + 1,
  localparam int         MAG_W   = GAP_W + 4,
  localparam int         SUM_W   = EXP_W + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          greedy,
  input  logic [2:0]    temp_code,
  input  logic          seed_load,
  input  logic [RW-1:0] seed_in,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] next_token,
  output logic [RW-1:0] rng_state
);
  smp_state_e         st_q, st_d;
  logic [AW:0]        ia_q, ia_d;
  logic               vld_q, vld_d;
  logic [AW-1:0]      vidx_q, vidx_d;
  logic signed [DW-1:0] max_q, max_d;
  logic [AW-1:0]      arg_q, arg_d;
  logic [SUM_W-1:0]   acc_q, acc_d, thr_q, thr_d, cum;
  logic               grd_q, grd_d;
  logic [2:0]         tc_q, tc_d;
  logic [RW-1:0]      rng_q, rng_d, rng_nx;
  logic [AW-1:0]      tok_q, tok_d;
  logic               done_q, done_d;
  logic               busy, issuing, last, better;
  logic [AW-1:0]      arg_n;
  logic signed [GAP_W-1:0] gap_s;
  logic [MAG_W-1:0]   mag;
  logic [EXP_W-1:0]   wgt;
  logic [SUM_W+15:0]  thr_prod;

  smp_scale #(.GAP_W(GAP_W), .MAG_W(MAG_W)) u_scale (
    .gap(gap_s[GAP_W-1:0]), .tcode(tc_q), .mag(mag));
  smp_exp #(.MAG_W(MAG_W)) u_exp (.mag(mag), .weight(wgt));
  smp_lcg #(.SW(RW)) u_lcg (.cur(rng_q), .nxt(rng_nx));

  always_comb begin
    busy     = (st_q != S_IDLE);
    issuing  = busy && (ia_q < (AW+1)'(VOCAB));
    rd_en    = issuing;
    rd_addr  = ia_q[AW-1:0];
    last     = vld_q && (vidx_q == AW'(VOCAB-1));
    better   = vld_q && ((vidx_q == '0) || ($signed(rd_data) > max_q));
    arg_n    = better ? vidx_q : arg_q;
    gap_s    = $signed({max_q[DW-1], max_q}) - $signed({rd_data[DW-1], rd_data});
    cum      = acc_q + SUM_W'(wgt);
    thr_prod = (SUM_W+16)'(rng_q[RW-1:RW-16]) * (SUM_W+16)'(cum);
  end

  // next-state process
  always_comb begin
    st_d = st_q;  ia_d = issuing ? ia_q + 1'b1 : ia_q;
    vld_d = issuing;  vidx_d = ia_q[AW-1:0];
    max_d = max_q;  arg_d = arg_q;  acc_d = acc_q;  thr_d = thr_q;
    grd_d = grd_q;  tc_d = tc_q;  rng_d = rng_q;  tok_d = tok_q;
    done_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d = S_MAX;  ia_d = '0;  grd_d = greedy;  tc_d = temp_code;
        end else if (seed_load) begin
          rng_d = seed_in;
        end
      end
      S_MAX: begin
        if (better) begin
          max_d = $signed(rd_data);  arg_d = vidx_q;
        end
        if (last) begin
          vld_d = 1'b0;
          if (grd_q) begin
            tok_d = arg_n;  st_d = S_IDLE;  done_d = 1'b1;
          end else begin
            rng_d = rng_nx;  st_d = S_SUM;  ia_d = '0;  acc_d = '0;
          end
        end
      end
      S_SUM: begin
        if (vld_q) acc_d = cum;
        if (last) begin
          thr_d = thr_prod[SUM_W+15:16];
          acc_d = '0;  st_d = S_PICK;  ia_d = '0;  vld_d = 1'b0;
        end
      end
      default: begin
        if (vld_q) begin
          acc_d = cum;
          if (cum > thr_q) begin
            tok_d = vidx_q;  st_d = S_IDLE;  done_d = 1'b1;  vld_d = 1'b0;
          end
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  ia_q <= '0;  vld_q <= 1'b0;  vidx_q <= '0;
      max_q <= '0;  arg_q <= '0;  acc_q <= '0;  thr_q <= '0;
      grd_q <= 1'b0;  tc_q <= '0;  rng_q <= RNG_RST;  tok_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;  ia_q <= ia_d;  vld_q <= vld_d;  vidx_q <= vidx_d;
      max_q <= max_d;  arg_q <= arg_d;  acc_q <= acc_d;  thr_q <= thr_d;
      grd_q <= grd_d;  tc_q <= tc_d;  rng_q <= rng_d;  tok_q <= tok_d;
      done_q <= done_d;
    end
  end

  assign done       = done_q;
  assign next_token = tok_q;
  assign rng_state  = rng_q;
endmodule

// File: rtl/token_sampler_chk.sv
module token_sampler_chk #(
  parameter int VOCAB = 27,
  parameter int AW    = 5,
  parameter int RW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seed_load,
  input logic          busy,
  input logic          done,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] next_token,
  input logic [RW-1:0] rng_state
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < AW'(VOCAB)));
  // R3
  token_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (next_token < AW'(VOCAB)));
  // R4
  rng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(seed_load) && !$past(busy)) |-> $stable(rng_state));
endmodule

bind token_sampler token_sampler_chk #(.VOCAB(VOCAB), .AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .busy(busy), .done(done),
  .rd_en(rd_en), .rd_addr(rd_addr), .next_token(next_token), .rng_state(rng_state));

// File: tb/sim_token_sampler.sv
module sim_token_sampler;
  localparam int VOCAB = 27;

  logic        clk, rst_n, start, greedy, seed_load;
  logic [2:0]  temp_code;
  logic [31:0] seed_in, rng_state;
  logic        rd_en, done;
  logic [4:0]  rd_addr, next_token;
  logic [15:0] rd_data;
  logic signed [15:0] mem [VOCAB];

  int checks = 0, fails = 0, bad_reads = 0, cycles = 0;

  token_sampler u0 (.clk(clk), .rst_n(rst_n), .start(start), .greedy(greedy),
    .temp_code(temp_code), .seed_load(seed_load), .seed_in(seed_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .next_token(next_token), .rng_state(rng_state));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rd_en) begin
      if (rd_addr < 5'(VOCAB)) rd_data <= mem[rd_addr];
      else bad_reads <= bad_reads + 1;
    end
  end

  typedef struct packed {
    logic [2:0]  pat;
    logic        grd;
    logic [2:0]  tc;
    logic        ld;
    logic [31:0] seed;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{3'd0, 1'b1, 3'd2, 1'b1, 32'd1234},
    '{3'd1, 1'b1, 3'd2, 1'b0, 32'd0},
    '{3'd3, 1'b1, 3'd2, 1'b0, 32'd0},
    '{3'd5, 1'b1, 3'd2, 1'b0, 32'd0},
    '{3'd4, 1'b1, 3'd2, 1'b0, 32'd0},
    '{3'd0, 1'b0, 3'd2, 1'b1, 32'hDEADBEEF},
    '{3'd1, 1'b0, 3'd0, 1'b0, 32'd0},
    '{3'd1, 1'b0, 3'd7, 1'b0, 32'd0},
    '{3'd4, 1'b0, 3'd2, 1'b0, 32'd0},
    '{3'd4, 1'b0, 3'd5, 1'b1, 32'd0},
    '{3'd2, 1'b0, 3'd7, 1'b0, 32'd0},
    '{3'd3, 1'b0, 3'd3, 1'b0, 32'd0},
    '{3'd5, 1'b0, 3'd2, 1'b0, 32'd0}
  };

  function automatic int logit(input int pat, input int k);
    case (pat)
      0: return 0;
      1: return k * 37 - 500;
      2: return (k == 13) ? 20480 : -20480;
      3: return (k == 5 || k == 20) ? 3000 : -1000;
      4: return ((k * 7919) % 4096) - 2048;
      default: return (k == 0) ? -32768 : 32767;
    endcase
  endfunction

  function automatic longint tpt(input int k);
    case (k)
      0: return 32768;  1: return 19875; 2: return 12055; 3: return 7312;
      4: return 4435;   5: return 2690;  6: return 1631;  7: return 990;
      8: return 600;    9: return 364;   10: return 221;  11: return 134;
      12: return 81;    13: return 49;   14: return 30;   15: return 18;
      default: return 11;
    endcase
  endfunction

  // R6 and R7 model
  function automatic longint ref_w(input int gap, input int tc);
    longint m, lo, hi;
    int k;
    m = (longint'(gap) * 10) / (5 + tc);
    if (m > 16384) return 0;
    k  = int'(m >> 10);
    lo = tpt(k);
    hi = (k >= 16) ? lo : tpt(k + 1);
    return lo - (((lo - hi) * (m & 1023)) >> 10);
  endfunction

  logic [31:0] m_rng;

  function automatic int ref_pick(input int pat, input bit grd, input int tc);
    int mx, am;
    longint sum, thr, cum;
    mx = logit(pat, 0); am = 0;
    for (int k = 1; k < VOCAB; k++)
      if (logit(pat, k) > mx) begin mx = logit(pat, k); am = k; end
    if (grd) return am;
    m_rng = m_rng * 32'd1664525 + 32'd1013904223;
    sum = 0;
    for (int k = 0; k < VOCAB; k++) sum += ref_w(mx - logit(pat, k), tc);
    thr = (longint'(m_rng[31:16]) * sum) >>> 16;
    cum = 0;
    for (int k = 0; k < VOCAB; k++) begin
      cum += ref_w(mx - logit(pat, k), tc);
      if (cum > thr) return k;
    end
    return -1;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_pat(input int pat);
    for (int k = 0; k < VOCAB; k++) mem[k] = 16'(logit(pat, k));
  endtask

  task automatic run(input bit grd, input int tc);
    int n;
    @(negedge clk);
    greedy = grd; temp_code = 3'(tc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) chk("R9 done timeout", 0, 1);
  endtask

  initial begin
    int exp_tok;
    logic [4:0] held;
    int extra;
    rst_n = 1'b0; start = 1'b0; greedy = 1'b0; temp_code = 3'd2;
    seed_load = 1'b0; seed_in = '0; m_rng = 32'd1;
    for (int k = 0; k < VOCAB; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 next_token", next_token, 0);
    chk("R1 rng_state", rng_state, 1);

    for (int i = 0; i < 13; i++) begin
      load_pat(int'(VECS[i].pat));
      if (VECS[i].ld) begin
        seed_in = VECS[i].seed; seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
        m_rng = VECS[i].seed;
        chk("R2 seed load", rng_state, VECS[i].seed);
      end
      exp_tok = ref_pick(int'(VECS[i].pat), VECS[i].grd, int'(VECS[i].tc));
      run(VECS[i].grd, int'(VECS[i].tc));
      if (VECS[i].grd) begin
        chk("R3 argmax token", next_token, exp_tok);
        chk("R4 rng unchanged", rng_state, m_rng);
      end else begin
        chk("R8 sampled token (R6 R7 scaling)", next_token, exp_tok);
        chk("R5 rng step", rng_state, m_rng);
      end
    end

    // R3 tie goes to lowest index; R7 cutoff makes the lone peak certain
    load_pat(3); run(1'b1, 2); chk("R3 tie lowest", next_token, 5);
    load_pat(5); run(1'b1, 2); chk("R3 extreme gap", next_token, 1);
    for (int s = 0; s < 4; s++) begin
      load_pat(2);
      exp_tok = ref_pick(2, 1'b0, 0);
      run(1'b0, 0);
      chk("R7 peak only", next_token, 13);
    end

    // R9 single-cycle done, token held
    held = next_token;
    @(negedge clk);
    chk("R9 done low", done, 0);
    repeat (5) @(negedge clk);
    chk("R9 token held", next_token, held);

    // R10 second start while busy is ignored
    load_pat(4);
    exp_tok = ref_pick(4, 1'b0, 4);
    @(negedge clk);
    greedy = 1'b0; temp_code = 3'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R10 token", next_token, exp_tok);
    extra = 0;
    repeat (150) begin @(negedge clk); if (done) extra++; end
    chk("R10 no extra done", extra, 0);
    chk("R10 rng single step", rng_state, m_rng);

    chk("R11 read range", bad_reads, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule